// File: doc/BRIEF.md
# Length-Sensing Serial Register Loader

This block takes configuration for a pulse generator over a three-wire serial link: an active-low select, a shift clock and a data line. While select is held low, the block samples the data line on each rising edge of the shift clock, most significant bit first, and counts the bits received. All three inputs pass through synchronisers into the system clock domain, so the serial clock must be slow compared with the system clock.

When select goes high again, the block looks only at the number of bits received. A 24-bit frame loads the control byte, the period byte and the pulse-width byte, in that order of arrival. A 16-bit frame loads period and pulse width. An 8-bit frame loads pulse width alone. Any other count loads nothing. Each load raises a one-cycle strobe toward the pulse generator. The control byte holds a clock-divide bit and a low-power bit. While the low-power bit is set, only a full 24-bit frame is accepted, and such a frame is the only way to clear the bit.

Top module: `serial_cfg_loader`

## Requirements
- R1: Bits are taken MSB first. In a frame of 8·k bits (k = 1, 2, 3), the last 8 bits received form the pulse-width byte, the 8 bits before them form the period byte, and the first 8 bits of a 24-bit frame form the control byte.
- R2: No output register changes and no strobe fires while select is low. Values are transferred only after select rises.
- R3: A 24-bit frame loads the control, period and pulse-width registers and pulses all three strobes.
- R4: A 16-bit frame loads period and pulse width, pulses only ld_period and ld_width, and leaves cd_q and pc_q unchanged.
- R5: An 8-bit frame loads pulse width only and pulses only ld_width.
- R6: A frame of any other length (0, 1–7, 9–15, 17–23 or more than 24 bits) is discarded. All registers keep their values and no strobe fires.
- R7: Control byte layout: bit 0 drives cd_q (clock divide) and bit 1 drives pc_q (low power). Bits 7 to 2 have no effect.
- R8: While pc_q is 1, 16-bit and 8-bit frames are discarded as in R6. A 24-bit frame is still accepted and may clear pc_q.
- R9: Strobes are single-cycle pulses. They are high during the cycle after the third rising system-clock edge that follows the rise of sel_n. Data registers take their new values on that same edge.
- R10: After reset, cd_q, pc_q, period_q and width_q are 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial shift clock, data sampled on rising edge |
| sdi | input | 1 | Serial data, MSB first |
| cd_q | output | 1 | Clock-divide bit of the control register |
| pc_q | output | 1 | Low-power bit of the control register |
| period_q | output | 8 | Period register |
| width_q | output | 8 | Pulse-width register |
| ld_ctrl | output | 1 | One-cycle strobe: control register loaded |
| ld_period | output | 1 | One-cycle strobe: period register loaded |
| ld_width | output | 1 | One-cycle strobe: pulse-width register loaded |

## Verification
Loads are timed from the rise of sel_n. Two synchroniser stages and one register in the decoder mean that strobes and new register values appear after the third system-clock edge. The bench raises sel_n between clock edges and then samples the strobes at the falling edges after edges one through four. It expects a pulse only at the third sample and checks the registers after the fourth. Serial bits are held for four system clocks on each phase of the shift clock, so every edge passes the synchronisers before the next one arrives. Just before each deselect, the bench checks that the outputs still hold their previous values.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [1:0] {
    LD_NONE  = 2'd0,
    LD_WIDTH = 2'd1,
    LD_PW_PR = 2'd2,
    LD_ALL   = 2'd3
  } load_kind_e;

  // Decide what a frame of nbits loads; low-power state admits only full frames.
  function automatic load_kind_e classify(input int nbits, input int word_w,
                                          input logic low_pwr);
    if (nbits == 3 * word_w)      return LD_ALL;
    else if (low_pwr)             return LD_NONE;
    else if (nbits == 2 * word_w) return LD_PW_PR;
    else if (nbits == word_w)     return LD_WIDTH;
    else                          return LD_NONE;
  endfunction

  // Saturating increment: stop one past the longest valid frame.
  function automatic int sat_inc(input int value, input int limit);
    return (value >= limit) ? limit : value + 1;
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
    else        pipe <= {pipe[STAGES-1:0], d};
  end

  assign q    = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/shift_counter.sv
module shift_counter
  import cfg_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int WORDS  = 3,
  localparam int TOT   = WORD_W * WORDS,
  localparam int CW    = $clog2(TOT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [TOT-1:0] sr,
  output logic [CW-1:0]  cnt
);
  localparam int LIMIT = TOT + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (!active) begin
      cnt <= '0;
    end else if (shift_en) begin
      sr  <= {sr[TOT-2:0], bit_in};
      cnt <= CW'(sat_inc(int'(cnt), LIMIT));
    end
  end

  // R6: count never exceeds the saturation value
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= LIMIT);
endmodule

// File: rtl/load_decoder.sv
module load_decoder
  import cfg_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int WORDS  = 3,
  localparam int TOT   = WORD_W * WORDS,
  localparam int CW    = $clog2(TOT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             sel_active,
  input  logic [TOT-1:0]   sr,
  input  logic [CW-1:0]    cnt,
  output logic             cd_q,
  output logic             pc_q,
  output logic [WORD_W-1:0] period_q,
  output logic [WORD_W-1:0] width_q,
  output logic             ld_ctrl,
  output logic             ld_period,
  output logic             ld_width
);
  load_kind_e kind;
  logic       take_ctrl, take_period, take_width;

  assign kind        = commit ? classify(int'(cnt), WORD_W, pc_q) : LD_NONE;
  assign take_ctrl   = (kind == LD_ALL);
  assign take_period = (kind == LD_ALL) || (kind == LD_PW_PR);
  assign take_width  = (kind != LD_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q <= 1'b0; pc_q <= 1'b0;
      period_q <= '0; width_q <= '0;
      ld_ctrl <= 1'b0; ld_period <= 1'b0; ld_width <= 1'b0;
    end else begin
      ld_ctrl   <= take_ctrl;
      ld_period <= take_period;
      ld_width  <= take_width;
      if (take_ctrl) begin
        cd_q <= sr[2*WORD_W];
        pc_q <= sr[2*WORD_W+1];
      end
      if (take_period) period_q <= sr[2*WORD_W-1:WORD_W];
      if (take_width)  width_q  <= sr[WORD_W-1:0];
    end
  end

  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_width |=> !ld_width);
  // R9
  strobe_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_width |-> $past(commit));
  // R3
  ctrl_implies_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ctrl |-> (ld_period && ld_width));
  // R4
  period_implies_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_period |-> ld_width);
  // R2
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_width |-> ($stable(width_q) && $stable(period_q) && $stable(pc_q)));
  // R2
  no_load_while_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_active |-> !take_width);
  // R8
  low_power_full_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_width && !ld_ctrl) |-> !pc_q);
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int WORDS  = 3,
  parameter int SYNC_STAGES = 2,
  localparam int TOT   = WORD_W * WORDS,
  localparam int CW    = $clog2(TOT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              cd_q,
  output logic              pc_q,
  output logic [WORD_W-1:0] period_q,
  output logic [WORD_W-1:0] width_q,
  output logic              ld_ctrl,
  output logic              ld_period,
  output logic              ld_width
);
  localparam logic [2:0] RST_VALS = 3'b100;

  logic [2:0] raw_in, lvl, rises, falls;
  assign raw_in = {sel_n, sck, sdi};

  for (genvar i = 0; i < 3; i++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_VALS[i])) sync_i (
      .clk(clk), .rst_n(rst_n), .d(raw_in[i]),
      .q(lvl[i]), .rise(rises[i]), .fall(falls[i]));
  end

  logic sel_active, sel_release, shift_pulse, bit_in, unused_edges;
  assign sel_active   = ~lvl[2];
  assign sel_release  = rises[2];
  assign shift_pulse  = rises[1] & sel_active;
  assign bit_in       = lvl[0];
  assign unused_edges = ^{falls, rises[0]};

  logic [TOT-1:0] sr;
  logic [CW-1:0]  cnt;

  shift_counter #(.WORD_W(WORD_W), .WORDS(WORDS)) shift_i (
    .clk(clk), .rst_n(rst_n), .active(sel_active),
    .shift_en(shift_pulse), .bit_in(bit_in), .sr(sr), .cnt(cnt));

  load_decoder #(.WORD_W(WORD_W), .WORDS(WORDS)) dec_i (
    .clk(clk), .rst_n(rst_n), .commit(sel_release), .sel_active(sel_active),
    .sr(sr), .cnt(cnt), .cd_q(cd_q), .pc_q(pc_q),
    .period_q(period_q), .width_q(width_q),
    .ld_ctrl(ld_ctrl), .ld_period(ld_period), .ld_width(ld_width));

  // R2
  no_shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |=> (cnt == '0));
endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic cd_q, pc_q, ld_ctrl, ld_period, ld_width;
  logic [7:0] period_q, width_q;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic       m_cd = 0, m_pc = 0;
  logic [7:0] m_per = 0, m_wid = 0;

  always #4 clk = ~clk;

  serial_cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .cd_q(cd_q), .pc_q(pc_q), .period_q(period_q), .width_q(width_q),
    .ld_ctrl(ld_ctrl), .ld_period(ld_period), .ld_width(ld_width));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected strobe set {ctrl, period, width} for a frame length.
  function automatic logic [2:0] exp_strobes(input int nbits, input logic lp);
    if (nbits == 24) return 3'b111;
    if (lp)          return 3'b000;
    if (nbits == 16) return 3'b011;
    if (nbits == 8)  return 3'b001;
    return 3'b000;
  endfunction

  function automatic string req_of(input int nbits, input logic lp);
    if (nbits == 24) return "R3";
    if (lp && (nbits == 16 || nbits == 8)) return "R8";
    if (nbits == 16) return "R4";
    if (nbits == 8)  return "R5";
    return "R6";
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // data: bit (nbits-1) is sent first
  task automatic xfer(input int nbits, input logic [31:0] data);
    logic [2:0] st, got;
    string req;
    st  = exp_strobes(nbits, m_pc);
    req = req_of(nbits, m_pc);
    @(negedge clk) sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = data[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    check("R2 hold during select", {cd_q, pc_q, period_q, width_q, ld_ctrl, ld_period, ld_width},
          {m_cd, m_pc, m_per, m_wid, 3'b000});
    sel_n = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      got = {ld_ctrl, ld_period, ld_width};
      check({"R9 strobe timing ", req}, got, (k == 3) ? st : 3'b000);
    end
    if (st[2]) begin m_cd = data[16]; m_pc = data[17]; end
    if (st[1]) m_per = data[15:8];
    if (st[0]) m_wid = data[7:0];
    check({req, " registers"}, {cd_q, pc_q, period_q, width_q}, {m_cd, m_pc, m_per, m_wid});
  endtask

  initial begin
    #(200000 * 8);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R10
    check("R10 reset", {cd_q, pc_q, period_q, width_q, ld_ctrl, ld_period, ld_width}, 21'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: MSB-first ordering across bytes
    xfer(16, 32'h0000_1234);
    check("R1 period byte", period_q, 8'h12);
    check("R1 width byte", width_q, 8'h34);
    // R7: upper control bits ignored, bit0 = cd
    xfer(24, 32'h00FD_5A0F);
    check("R7 cd from bit0", {cd_q, pc_q}, 2'b10);
    // R8: set low power, short writes ignored
    xfer(24, 32'h0002_0A03);
    check("R7 pc from bit1", {cd_q, pc_q}, 2'b01);
    xfer(8, 32'h0000_00AA);
    xfer(16, 32'h0000_BBCC);
    check("R8 width kept", width_q, 8'h03);
    xfer(24, 32'h0000_0706);
    check("R8 pc cleared", pc_q, 1'b0);
    // R5 / R6 boundaries
    xfer(8, 32'h0000_0055);
    xfer(0, 32'h0);
    xfer(7, 32'h0000_007F);
    xfer(9, 32'h0000_01FF);
    xfer(23, 32'h007F_FFFF);
    xfer(25, 32'h01FF_FFFF);
    xfer(30, 32'h3FFF_FFFF);

    for (int t = 0; t < 150; t++) begin
      int r, n;
      logic [31:0] d;
      r = $urandom % 8;
      n = (r < 3) ? 24 : (r < 5) ? 16 : (r < 7) ? 8 : int'($urandom % 31);
      d = $urandom;
      if (n == 24 && ($urandom % 4) != 0) d[17] = 1'b0;
      xfer(n, d);
    end
    report();
  end
endmodule